// File: doc/BRIEF.md
# Dual-Channel DAC Register Controller

This block holds the digital code registers of a two-channel digital-to-analog converter. Each channel has two registers. The input register is written by the host. The output register drives the converter's code. A host word can write the input register only, or it can write both registers at once. An active-low load strobe moves new input data into the output registers, so both channels can change on the same edge. The strobe can be pulsed, or it can be tied low so that each write reaches the output at once.

A separate active-low preset input acts on its falling edge and forces every register to a preset code. While it stays low, the load strobe has no effect. A strap input selects the preset: zero scale or midscale. The same strap also sets the codes at system reset. Each channel has a pending flag that shows its input register holds data not yet moved to the output register.

Top module: `dac_reg_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both input and output registers take the preset code chosen by `mid_sel`, and `pending` is 0.
- R2: A host word with command 4'h1 updates the input register of each addressed channel and sets its pending flag; the output code is unchanged while the synchronised strobe is high.
- R3: Command 4'h3 writes both the input and the output register of each addressed channel on the clock edge that takes the word, and clears its pending flag.
- R4: The word is split as command in bits [23:20], channel mask in bits [19:16] (bit 16 = channel A, bit 17 = channel B, bits 18 and 19 ignored), and code in bits [15:4]; bits [3:0] are ignored. Both channels can be addressed by a single word.
- R5: Command codes other than 4'h1 and 4'h3 change no register and no pending flag.
- R6: `load_n` passes through a two-stage synchroniser. From the third clock edge after it goes low, each channel with its pending flag set copies its input register to its output register and clears the flag. Channels without pending data keep their output.
- R7: While `load_n` is held low, a command 4'h1 write reaches the output on the same edge that takes the word, and the pending flag stays 0.
- R8: If a write and an active load fall on the same edge, the new code is what the output register receives.
- R9: A falling edge of `preset_n`, seen after a two-stage synchroniser, loads the preset code into all four registers and clears both pending flags. This takes priority over any write on that edge.
- R10: While the synchronised `preset_n` is low, load strobes are ignored, but host writes still update the input registers and pending flags.
- R11: `mid_sel` low selects preset code 12'h000 (zero scale); high selects 12'h800 (midscale).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| wr_valid | input | 1 | Host word valid for one cycle |
| wr_word | input | 24 | Host word: command, channel mask, code |
| load_n | input | 1 | Asynchronous active-low load strobe |
| preset_n | input | 1 | Asynchronous preset input, acts on its falling edge |
| mid_sel | input | 1 | Preset select: 0 zero scale, 1 midscale |
| dac_codes | output | 24 | Output register codes, channel B in [23:12], A in [11:0] |
| pending | output | 2 | Pending flag per channel, bit 0 = A |

## Verification
The bench sweeps all sixteen command codes against all four channel masks. Each word carries a code derived from its indices, and about half the words are followed by a load pulse. This separates input-only writes, direct writes and ignored commands, and it shows that a load moves only the channels with pending data. The tied-low strobe mode and a write that lands exactly on the first active load edge show whether the write or the transfer wins. Preset sequences with both strap values, with writes and load pulses while the preset is held, show the zero/midscale selection and the load blocking.

// File: rtl/dac_reg_pkg.sv
// Package: shared widths, command codes and word layout for the DAC
// register controller. Assumes at most MASK_W channels.
package dac_reg_pkg;
    localparam int DATA_W  = 12;
    localparam int NUM_CH  = 2;
    localparam int CMD_W   = 4;
    localparam int MASK_W  = 4;
    localparam int FIELD_W = 16;
    localparam int WORD_W  = CMD_W + MASK_W + FIELD_W;
    localparam int PAD_W   = FIELD_W - DATA_W;

    localparam logic [CMD_W-1:0] CMD_WR_INPUT  = 4'h1;
    localparam logic [CMD_W-1:0] CMD_WR_DIRECT = 4'h3;

    typedef struct packed {
        logic [CMD_W-1:0]   cmd;
        logic [MASK_W-1:0]  mask;
        logic [FIELD_W-1:0] field;
    } host_word_t;

    // Preset code: zero scale or midscale (only the MSB set).
    function automatic logic [DATA_W-1:0] preset_code(input logic mid);
        preset_code = mid ? {1'b1, {(DATA_W-1){1'b0}}} : '0;
    endfunction
endpackage

// File: rtl/dac_sync.sv
// Module: multi-stage synchroniser for one asynchronous control line.
// Assumes STAGES >= 2; the chain resets to RST_VAL (the idle level).
module dac_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flip-flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/dac_cmd_decode.sv
// Module: splits a host word into per-channel write enables and a code.
// Assumes the code is left-justified in the data field; mask bits for
// channels that do not exist and the low pad bits are ignored.
module dac_cmd_decode
    import dac_reg_pkg::*;
(
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_word,
    output logic [NUM_CH-1:0] wr_input,
    output logic [NUM_CH-1:0] wr_direct,
    output logic [DATA_W-1:0] wr_code
);
    host_word_t word;
    logic       is_input;
    logic       is_direct;
    logic       unused_bits;

    assign word        = host_word_t'(wr_word);
    assign is_direct   = wr_valid && (word.cmd == CMD_WR_DIRECT);
    assign is_input    = is_direct || (wr_valid && (word.cmd == CMD_WR_INPUT));
    assign wr_code     = word.field[FIELD_W-1:PAD_W];
    assign unused_bits = ^{word.field[PAD_W-1:0], word.mask[MASK_W-1:NUM_CH]};

    // One enable pair per channel, gated by its mask bit.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign wr_input[c]  = is_input  && word.mask[c];
        assign wr_direct[c] = is_direct && word.mask[c];
    end
endmodule

// File: rtl/dac_channel.sv
// Module: one channel's input register, output register and pending flag.
// Assumes xfer_en already folds in the preset-hold blocking; preset_hit
// overrides every other action on its cycle.
module dac_channel
    import dac_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] preset,
    input  logic              preset_hit,
    input  logic              xfer_en,
    input  logic              wr_input,
    input  logic              wr_direct,
    input  logic [DATA_W-1:0] wr_code,
    output logic [DATA_W-1:0] out_code,
    output logic              pend
);
    logic [DATA_W-1:0] in_reg;

    // Input register: preset on reset, else takes each addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n || preset_hit) in_reg <= preset;
        else if (wr_input)        in_reg <= wr_code;
    end

    // Output register and pending flag: the write is applied before the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || preset_hit) begin
            out_code <= preset;
            pend     <= 1'b0;
        end else if (wr_direct || (wr_input && xfer_en)) begin
            out_code <= wr_code;
            pend     <= 1'b0;
        end else if (xfer_en && pend) begin
            out_code <= in_reg;
            pend     <= 1'b0;
        end else if (wr_input) begin
            pend     <= 1'b1;
        end
    end
endmodule

// File: rtl/dac_reg_ctrl.sv
// Module: top of the double-buffered dual-channel DAC register controller.
// Assumes load_n and preset_n are asynchronous and idle high, and that
// mid_sel is a static strap.
module dac_reg_ctrl
    import dac_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic [WORD_W-1:0]        wr_word,
    input  logic                     load_n,
    input  logic                     preset_n,
    input  logic                     mid_sel,
    output logic [NUM_CH*DATA_W-1:0] dac_codes,
    output logic [NUM_CH-1:0]        pending
);
    logic              ld_sync;
    logic              clr_sync;
    logic              clr_sync_d;
    logic              clr_fall;
    logic              xfer_en;
    logic [DATA_W-1:0] preset;
    logic [NUM_CH-1:0] wr_input;
    logic [NUM_CH-1:0] wr_direct;
    logic [DATA_W-1:0] wr_code;

    dac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ld_sync (
        .clk(clk), .rst_n(rst_n), .din(load_n), .dout(ld_sync));

    dac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_clr_sync (
        .clk(clk), .rst_n(rst_n), .din(preset_n), .dout(clr_sync));

    // Delay the synchronised preset line for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_sync_d <= 1'b1;
        else        clr_sync_d <= clr_sync;
    end

    assign clr_fall = clr_sync_d && !clr_sync;
    assign xfer_en  = !ld_sync && clr_sync;
    assign preset   = preset_code(mid_sel);

    dac_cmd_decode u_dec (
        .wr_valid(wr_valid), .wr_word(wr_word),
        .wr_input(wr_input), .wr_direct(wr_direct), .wr_code(wr_code));

    // One register pair per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dac_channel u_chan (
            .clk(clk), .rst_n(rst_n), .preset(preset), .preset_hit(clr_fall),
            .xfer_en(xfer_en), .wr_input(wr_input[c]), .wr_direct(wr_direct[c]),
            .wr_code(wr_code), .out_code(dac_codes[c*DATA_W +: DATA_W]),
            .pend(pending[c]));
    end
endmodule

// File: rtl/dac_reg_ctrl_checker.sv
// Module: temporal checks on the register controller, bound to its top.
module dac_reg_ctrl_checker
    import dac_reg_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_valid,
    input logic [WORD_W-1:0]        wr_word,
    input logic                     mid_sel,
    input logic [NUM_CH*DATA_W-1:0] dac_codes,
    input logic [NUM_CH-1:0]        pending,
    input logic                     ld_sync,
    input logic                     clr_sync,
    input logic                     clr_fall
);
    logic [CMD_W-1:0] cmd;
    assign cmd = wr_word[WORD_W-1 -: CMD_W];

    assert_preset_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fall |=> (dac_codes == {NUM_CH{preset_code($past(mid_sel))}}) && (pending == '0));

    assert_load_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_sync && !clr_fall && !wr_valid) |=> $stable(dac_codes));

    assert_load_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_sync && clr_sync) |=> (pending == '0));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sync && !wr_valid && !clr_fall) |=> $stable(dac_codes));

    assert_pend_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && cmd == CMD_WR_INPUT && wr_word[FIELD_W] && !clr_fall
         && (ld_sync || !clr_sync)) |=> pending[0]);

    assert_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && cmd == CMD_WR_DIRECT && wr_word[FIELD_W] && !clr_fall)
        |=> (dac_codes[DATA_W-1:0] == $past(wr_word[FIELD_W-1 -: DATA_W])));

    assert_ignored_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && cmd != CMD_WR_INPUT && cmd != CMD_WR_DIRECT && ld_sync && !clr_fall)
        |=> ($stable(dac_codes) && $stable(pending)));
endmodule

bind dac_reg_ctrl dac_reg_ctrl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
    .mid_sel(mid_sel), .dac_codes(dac_codes), .pending(pending),
    .ld_sync(ld_sync), .clr_sync(clr_sync), .clr_fall(clr_fall));

// File: tb/dac_reg_ctrl_test.sv
module dac_reg_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [23:0] wr_word = '0;
    logic        load_n = 1'b1;
    logic        preset_n = 1'b1;
    logic        mid_sel = 1'b1;
    logic [23:0] dac_codes;
    logic [1:0]  pending;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model
    logic [11:0] m_in [2];
    logic [11:0] m_dac [2];
    logic [1:0]  m_pend;
    bit          ld_low  = 0;
    bit          clr_low = 0;

    dac_reg_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
        .load_n(load_n), .preset_n(preset_n), .mid_sel(mid_sel),
        .dac_codes(dac_codes), .pending(pending));

    always #5 clk = ~clk;

    function automatic logic [11:0] preset_of(input logic mid);
        return mid ? 12'h800 : 12'h000;
    endfunction

    task automatic check(input string req);
        logic [23:0] exp_codes;
        exp_codes = {m_dac[1], m_dac[0]};
        checks++;
        if (dac_codes !== exp_codes || pending !== m_pend) begin
            fails++;
            $display("FAIL %s: codes=%h pending=%b expected codes=%h pending=%b",
                     req, dac_codes, pending, exp_codes, m_pend);
        end
    endtask

    task automatic model_preset();
        for (int c = 0; c < 2; c++) begin
            m_in[c]  = preset_of(mid_sel);
            m_dac[c] = preset_of(mid_sel);
        end
        m_pend = 2'b00;
    endtask

    task automatic model_write(input logic [3:0] cmd, input logic [1:0] mask,
                               input logic [11:0] d);
        for (int c = 0; c < 2; c++) begin
            if (mask[c] && (cmd == 4'h1 || cmd == 4'h3)) begin
                m_in[c] = d;
                if (cmd == 4'h3 || (ld_low && !clr_low)) begin
                    m_dac[c] = d;
                    m_pend[c] = 1'b0;
                end else begin
                    m_pend[c] = 1'b1;
                end
            end
        end
    endtask

    task automatic model_transfer();
        if (!clr_low)
            for (int c = 0; c < 2; c++)
                if (m_pend[c]) begin
                    m_dac[c] = m_in[c];
                    m_pend[c] = 1'b0;
                end
    endtask

    // One word presented across exactly one rising edge; also sets ignored upper mask bits.
    task automatic host_write(input logic [3:0] cmd, input logic [1:0] mask,
                              input logic [11:0] d);
        wr_word  = {cmd, 2'b10, mask, d, 4'hA};
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        model_write(cmd, mask, d);
    endtask

    task automatic load_pulse();
        load_n = 1'b0;
        repeat (4) @(negedge clk);
        model_transfer();
        load_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic preset_fall(input logic mid);
        mid_sel  = mid;
        preset_n = 1'b0;
        repeat (4) @(negedge clk);
        clr_low = 1;
        model_preset();
    endtask

    task automatic preset_release();
        preset_n = 1'b1;
        repeat (4) @(negedge clk);
        clr_low = 0;
    endtask

    initial begin
        m_pend = '0;
        // R1 / R11: power-up with midscale strap
        repeat (3) @(negedge clk);
        model_preset();
        check("R1 R11 reset midscale");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        // Sweep: all commands by all masks (R2 R3 R4 R5 R6)
        for (int cmd = 0; cmd < 16; cmd++) begin
            for (int mask = 0; mask < 4; mask++) begin
                logic [11:0] d;
                d = 12'((cmd * 263 + mask * 97 + 5) & 12'hFFF);
                host_write(4'(cmd), 2'(mask), d);
                check((cmd == 1) ? "R2 R4 input write" :
                      (cmd == 3) ? "R3 R4 direct write" : "R5 ignored command");
                if (((cmd + mask) % 2) == 1) begin
                    load_pulse();
                    check("R6 load pending only");
                end
            end
        end

        // Both channels pending, one pulse updates both
        host_write(4'h1, 2'b01, 12'h123);
        host_write(4'h1, 2'b10, 12'hABC);
        check("R2 both pending");
        load_pulse();
        check("R6 simultaneous update");

        // R8: write lands on the first edge where the synchronised strobe is low
        host_write(4'h1, 2'b01, 12'h456);
        load_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_word  = {4'h1, 4'b0001, 12'h789, 4'h0};
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        m_in[0] = 12'h789; m_dac[0] = 12'h789; m_pend[0] = 1'b0;
        check("R8 write wins over transfer");
        load_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7: strobe tied low, each write goes straight through
        load_n = 1'b0;
        repeat (4) @(negedge clk);
        ld_low = 1;
        for (int k = 0; k < 6; k++) begin
            host_write(4'h1, 2'(k % 3 + 1), 12'(k * 611 + 17));
            check("R7 tied-low follow");
        end
        load_n = 1'b1;
        repeat (4) @(negedge clk);
        ld_low = 0;

        // R9 R11: zero-scale preset
        host_write(4'h1, 2'b11, 12'h3C3);
        preset_fall(1'b0);
        check("R9 R11 preset zero scale");
        // R10: writes still land, loads ignored while held
        host_write(4'h1, 2'b11, 12'h5A5);
        check("R10 write during preset hold");
        load_pulse();
        check("R10 load ignored during hold");
        host_write(4'h3, 2'b10, 12'h777);
        check("R10 direct write during hold");
        preset_release();
        check("R10 release keeps state");
        load_pulse();
        check("R6 load after release");

        // R9 R11: midscale preset
        host_write(4'h1, 2'b01, 12'h0F0);
        preset_fall(1'b1);
        check("R9 R11 preset midscale");
        preset_release();
        load_pulse();
        check("R9 pending cleared by preset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule